// File: doc/BRIEF.md
# SPI Slave with Address Filtering

This block is the slave end of a four-wire serial peripheral link. It runs on a fast system clock, brings the external serial clock, data-in and active-low select lines into that clock domain through two-flop synchronizers, and finds serial clock edges by comparing successive synchronized samples. The system clock must run at least four times faster than the serial clock. All four clock polarity and phase settings are supported, and characters are either eight or nine bits long, most significant bit first.

On the system side, a character written to the transmit register is sent on the data-out line. The line has its own output enable, which is low while the slave is not taking part in a transfer. Each received character goes into a one-entry receive buffer with a valid flag and a sticky overflow flag. Reading the buffer clears both flags.

With address filtering on, the first character of every transaction is compared with a programmed address. If they differ, the rest of the transaction is ignored and the output stays disabled. If they match, the output is enabled, a one-cycle wake pulse is raised, and the following characters are handled as data.

Top module: `spi_addr_slave`

## Requirements
- R1: While the synchronized select is high, `spi_miso_oe` is 0 and no character is received. The enable is also 0 out of reset. Without address filtering, the enable goes to 1 as soon as the select falls.
- R2: If the select rises in the middle of a character, the partial character is dropped. The next transaction starts from bit 0 of both the receive and the transmit character.
- R3: A leading edge is the serial clock leaving its idle level (`cfg_cpol`). With `cfg_cpha`=0, data-in is sampled on leading edges, data-out changes on trailing edges, and the first bit is driven as soon as the select falls. With `cfg_cpha`=1, data-out changes on leading edges and data-in is sampled on trailing edges.
- R4: `cfg_nine_bit`=1 selects nine-bit characters and 0 selects eight-bit characters, both sent MSB first. In eight-bit mode, bit 8 of `rx_data` reads 0 and bit 8 of the address is not compared.
- R5: With `cfg_addr_en`=1, the first character after the select falls is compared with `cfg_addr`. The output enable is 0 while that character is shifted. The address character never enters the receive buffer. On a mismatch, no character of that transaction is stored and the enable stays 0 until the select rises.
- R6: On an address match, `spi_miso_oe` goes to 1 and `wake` is high for exactly one system cycle.
- R7: Each data character that completes is placed in `rx_data` and sets `rx_valid`. A one-cycle `rx_rd` clears `rx_valid`.
- R8: If a character completes while `rx_valid` is 1 and no read is made in that cycle, the character is dropped and `rx_overflow` is set. `rx_data` keeps the older character, and `rx_rd` clears the flag.
- R9: If no write has been accepted for a character, that character repeats the one sent before it.
- R10: A write made while the select is high is sent in the first data character. A write made during a transaction is taken at the next character boundary only if at least three leading edges came between the write and that boundary. Otherwise it is held for the boundary after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (0 = high impedance) |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Clock phase: 0 = sample on leading edges, 1 = sample on trailing edges |
| cfg_nine_bit | input | 1 | 1 = nine-bit characters, 0 = eight-bit characters |
| cfg_addr_en | input | 1 | Enables address filtering |
| cfg_addr | input | 9 | Address compared with the first character |
| tx_data | input | 9 | Character to transmit |
| tx_wr | input | 1 | One-cycle write strobe for `tx_data` |
| rx_data | output | 9 | Receive buffer |
| rx_valid | output | 1 | Receive buffer holds an unread character |
| rx_rd | input | 1 | One-cycle read strobe |
| rx_overflow | output | 1 | A character was dropped because the buffer was full |
| wake | output | 1 | One-cycle pulse on an address match |

## Verification
The first sweep covers every combination of polarity, phase and character size, each with its own transmit and receive values. A swapped edge, a wrong bit order or a wrong upper bit therefore shows up as a data mismatch in that configuration only. Streams of several characters are run three ways: with no writes, with a write just before the last bit, and with a write early in a character. These separate repeating the previous character, holding a late write and taking an aged write. Address tests send an equal address, an address that differs in its lowest bit, and an eight-bit address whose ninth programmed bit must be ignored. A transfer cut off after three bits confirms that the bit counters are resynchronized.

// File: rtl/spi_as_pkg.sv
package spi_as_pkg;

    localparam int CHAR_W      = 9;
    localparam int CNT_W       = $clog2(CHAR_W + 1);
    localparam int SYNC_STAGES = 2;
    localparam int TX_AGE_MIN  = 3;
    localparam int AGE_W       = $clog2(TX_AGE_MIN + 1);

    typedef logic [CHAR_W-1:0] char_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [AGE_W-1:0]  age_t;

    localparam age_t AGE_MAX = age_t'(TX_AGE_MIN);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic lead;
        logic sample;
        logic shift;
    } sck_ev_t;

    typedef struct packed {
        logic  cpha;
        logic  nine;
        logic  addr_en;
        char_t addr;
    } frame_cfg_t;

    function automatic cnt_t char_len(logic nine);
        return nine ? cnt_t'(CHAR_W) : cnt_t'(CHAR_W - 1);
    endfunction

    function automatic char_t char_mask(char_t c, logic nine);
        return nine ? c : {1'b0, c[CHAR_W-2:0]};
    endfunction

    // MSB-first bit selection: index 0 is the top bit of the active size
    function automatic logic pick_bit(char_t c, logic nine, cnt_t idx);
        cnt_t pos;
        pos = char_len(nine) - cnt_t'(1) - idx;
        return c[pos];
    endfunction

endpackage

// File: rtl/spi_as_sync.sv
module spi_as_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_as_edge.sv
module spi_as_edge
    import spi_as_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sck_s,
    input  logic    ss_n_s,
    input  logic    cpol,
    input  logic    cpha,
    output sck_ev_t ev,
    output logic    active,
    output logic    ss_fall
);

    logic sck_d;
    logic ss_d;
    logic lead;
    logic trail;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            ss_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            ss_d  <= ss_n_s;
        end
    end

    always_comb begin
        active    = !ss_n_s;
        lead      = active && (sck_d == cpol) && (sck_s != cpol);
        trail     = active && (sck_d != cpol) && (sck_s == cpol);
        ev.lead   = lead;
        ev.sample = cpha ? trail : lead;
        ev.shift  = cpha ? lead : trail;
        ss_fall   = ss_d && !ss_n_s;
    end

endmodule

// File: rtl/spi_as_frame.sv
module spi_as_frame
    import spi_as_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_cfg_t cfg,
    input  sck_ev_t    ev,
    input  logic       active,
    input  logic       ss_fall,
    input  logic       mosi_s,
    input  logic       tx_wr,
    input  char_t      tx_data,
    output logic       miso,
    output logic       oe,
    output logic       wake,
    output logic       push,
    output char_t      push_data
);

    phase_t            phase;
    cnt_t              cnt;
    cnt_t              out_idx;
    cnt_t              len;
    logic [CHAR_W-2:0] rx_sh;
    char_t             rx_next;
    char_t             char_in;
    char_t             tx_cur;
    char_t             tx_hold;
    char_t             fall_sel;
    logic              tx_pend;
    age_t              tx_age;
    age_t              age_inc;
    logic              done;
    logic              aged;
    logic              addr_hit;

    always_comb begin
        len      = char_len(cfg.nine);
        rx_next  = {rx_sh, mosi_s};
        char_in  = char_mask(rx_next, cfg.nine);
        done     = ev.sample && (cnt == len - cnt_t'(1));
        age_inc  = (ev.lead && tx_age != AGE_MAX) ? tx_age + age_t'(1) : tx_age;
        aged     = tx_pend && (age_inc == AGE_MAX);
        fall_sel = tx_pend ? tx_hold : tx_cur;
        addr_hit = (char_in == char_mask(cfg.addr, cfg.nine));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            out_idx   <= '0;
            rx_sh     <= '0;
            tx_cur    <= '0;
            tx_hold   <= '0;
            tx_pend   <= 1'b0;
            tx_age    <= '0;
            miso      <= 1'b0;
            oe        <= 1'b0;
            wake      <= 1'b0;
            push      <= 1'b0;
            push_data <= '0;
        end else begin
            wake   <= 1'b0;
            push   <= 1'b0;
            tx_age <= age_inc;
            if (!active) begin
                phase   <= PH_IDLE;
                cnt     <= '0;
                out_idx <= '0;
                oe      <= 1'b0;
            end else if (ss_fall) begin
                cnt <= '0;
                if (cfg.addr_en) begin
                    phase   <= PH_ADDR;
                    oe      <= 1'b0;
                    out_idx <= '0;
                end else begin
                    phase   <= PH_DATA;
                    oe      <= 1'b1;
                    tx_cur  <= fall_sel;
                    tx_pend <= 1'b0;
                    if (!cfg.cpha) begin
                        miso    <= pick_bit(fall_sel, cfg.nine, cnt_t'(0));
                        out_idx <= cnt_t'(1);
                    end else begin
                        out_idx <= '0;
                    end
                end
            end else begin
                if (ev.shift && out_idx < len) begin
                    miso    <= pick_bit(tx_cur, cfg.nine, out_idx);
                    out_idx <= out_idx + cnt_t'(1);
                end
                if (ev.sample) begin
                    rx_sh <= rx_next[CHAR_W-2:0];
                    if (done) begin
                        cnt     <= '0;
                        out_idx <= '0;
                        if (phase == PH_ADDR) begin
                            if (addr_hit) begin
                                phase <= PH_DATA;
                                oe    <= 1'b1;
                                wake  <= 1'b1;
                                if (aged) begin
                                    tx_cur  <= tx_hold;
                                    tx_pend <= 1'b0;
                                end
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end else if (phase == PH_DATA) begin
                            push      <= 1'b1;
                            push_data <= char_in;
                            if (aged) begin
                                tx_cur  <= tx_hold;
                                tx_pend <= 1'b0;
                            end
                        end
                    end else begin
                        cnt <= cnt + cnt_t'(1);
                    end
                end
            end
            if (tx_wr) begin
                tx_hold <= tx_data;
                tx_pend <= 1'b1;
                tx_age  <= '0;
            end
        end
    end

    // R1
    inactive_oe_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> !oe);

    // R6
    wake_oe_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> oe);

    // R7
    push_oe_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (oe && phase == PH_DATA));

    // R4
    bit_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < len));

endmodule

// File: rtl/spi_as_rxbuf.sv
module spi_as_rxbuf
    import spi_as_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  char_t push_data,
    input  logic  rd,
    output char_t data,
    output logic  valid,
    output logic  ovf
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            valid <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            if (push && (!valid || rd)) begin
                data  <= push_data;
                valid <= 1'b1;
            end else if (rd) begin
                valid <= 1'b0;
            end
            if (push && valid && !rd) begin
                ovf <= 1'b1;
            end else if (rd) begin
                ovf <= 1'b0;
            end
        end
    end

    // R8
    ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(valid));

    // R8
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !rd) |=> $stable(data));

endmodule

// File: rtl/spi_addr_slave.sv
module spi_addr_slave
    import spi_as_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        spi_sck,
    input  logic        spi_mosi,
    input  logic        spi_ss_n,
    output logic        spi_miso,
    output logic        spi_miso_oe,
    input  logic        cfg_cpol,
    input  logic        cfg_cpha,
    input  logic        cfg_nine_bit,
    input  logic        cfg_addr_en,
    input  logic [8:0]  cfg_addr,
    input  logic [8:0]  tx_data,
    input  logic        tx_wr,
    output logic [8:0]  rx_data,
    output logic        rx_valid,
    input  logic        rx_rd,
    output logic        rx_overflow,
    output logic        wake
);

    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_s;
    sck_ev_t          ev;
    logic             active;
    logic             ss_fall;
    frame_cfg_t       fcfg;
    logic             push;
    char_t            push_data;

    spi_as_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({spi_ss_n, spi_mosi, spi_sck}),
        .q  (pins_s)
    );

    spi_as_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sck_s  (pins_s[0]),
        .ss_n_s (pins_s[2]),
        .cpol   (cfg_cpol),
        .cpha   (cfg_cpha),
        .ev     (ev),
        .active (active),
        .ss_fall(ss_fall)
    );

    always_comb begin
        fcfg.cpha    = cfg_cpha;
        fcfg.nine    = cfg_nine_bit;
        fcfg.addr_en = cfg_addr_en;
        fcfg.addr    = cfg_addr;
    end

    spi_as_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .cfg      (fcfg),
        .ev       (ev),
        .active   (active),
        .ss_fall  (ss_fall),
        .mosi_s   (pins_s[1]),
        .tx_wr    (tx_wr),
        .tx_data  (tx_data),
        .miso     (spi_miso),
        .oe       (spi_miso_oe),
        .wake     (wake),
        .push     (push),
        .push_data(push_data)
    );

    spi_as_rxbuf u_rxbuf (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_data(push_data),
        .rd       (rx_rd),
        .data     (rx_data),
        .valid    (rx_valid),
        .ovf      (rx_overflow)
    );

endmodule

// File: tb/tb_spi_addr_slave.sv
module tb_spi_addr_slave;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       spi_sck, spi_mosi, spi_ss_n;
    logic       spi_miso, spi_miso_oe;
    logic       cfg_cpol, cfg_cpha, cfg_nine_bit, cfg_addr_en;
    logic [8:0] cfg_addr, tx_data, rx_data;
    logic       tx_wr, rx_valid, rx_rd, rx_overflow, wake;

    int checks = 0;
    int fails  = 0;
    int wake_cnt = 0;
    int oe_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_addr_slave dut (
        .clk(clk), .rst(rst),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_ss_n(spi_ss_n),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_nine_bit(cfg_nine_bit),
        .cfg_addr_en(cfg_addr_en), .cfg_addr(cfg_addr),
        .tx_data(tx_data), .tx_wr(tx_wr),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_rd(rx_rd),
        .rx_overflow(rx_overflow), .wake(wake)
    );

    always @(posedge clk) begin
        if (wake) wake_cnt++;
        if (spi_miso_oe) oe_cnt++;
    end

    function automatic logic [8:0] msk(logic [8:0] v, logic nine);
        return nine ? v : {1'b0, v[7:0]};
    endfunction

    task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(logic [8:0] v);
        @(negedge clk);
        tx_data = v;
        tx_wr   = 1'b1;
        @(negedge clk);
        tx_wr   = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [8:0] exp);
        @(negedge clk);
        chk({tag, " valid"}, {8'b0, rx_valid}, 9'd1);
        chk({tag, " data"}, rx_data, exp);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic setup(logic p, logic h, logic nine, logic aen, logic [8:0] a);
        @(negedge clk);
        cfg_cpol = p; cfg_cpha = h; cfg_nine_bit = nine;
        cfg_addr_en = aen; cfg_addr = a;
        spi_sck = p;
        cyc(4);
    endtask

    task automatic ss_low();
        @(negedge clk);
        spi_ss_n = 1'b0;
        cyc(HALF);
    endtask

    task automatic ss_high();
        cyc(HALF);
        spi_ss_n = 1'b1;
        cyc(2 * HALF);
    endtask

    task automatic xfer(input int n, input logic [8:0] mo, input int wr_at,
                        input logic [8:0] wr_val, output logic [8:0] mi);
        mi = '0;
        for (int i = 0; i < n; i++) begin
            logic [8:0] t;
            t = mo >> (n - 1 - i);
            if (i == wr_at) write(wr_val);
            @(negedge clk);
            if (!cfg_cpha) begin
                spi_mosi = t[0];
                cyc(HALF);
                spi_sck = ~cfg_cpol;
                mi = {mi[7:0], spi_miso};
                cyc(HALF);
                spi_sck = cfg_cpol;
            end else begin
                spi_sck = ~cfg_cpol;
                spi_mosi = t[0];
                cyc(HALF);
                spi_sck = cfg_cpol;
                mi = {mi[7:0], spi_miso};
                cyc(HALF);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [8:0] mi;
        int bw, bo;
        rst = 1'b1; spi_sck = 1'b0; spi_mosi = 1'b0; spi_ss_n = 1'b1;
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_nine_bit = 1'b0;
        cfg_addr_en = 1'b0; cfg_addr = '0; tx_data = '0; tx_wr = 1'b0; rx_rd = 1'b0;
        cyc(5);
        rst = 1'b0;
        cyc(3);

        chk("R1 oe after reset", {8'b0, spi_miso_oe}, 9'd0);
        chk("R7 valid after reset", {8'b0, rx_valid}, 9'd0);
        chk("R8 overflow after reset", {8'b0, rx_overflow}, 9'd0);
        chk("R6 wake after reset", {8'b0, wake}, 9'd0);

        // R3 R4: every polarity, phase and size
        for (int m = 0; m < 4; m++) begin
            for (int nb = 0; nb < 2; nb++) begin
                logic [8:0] tv, mv;
                tv = msk(9'h1A5 ^ 9'(m * 37 + nb * 11), nb[0]);
                mv = msk(9'h0C3 + 9'(m * 17 + nb * 100), nb[0]);
                setup(m[1], m[0], nb[0], 1'b0, 9'h0);
                write(tv);
                ss_low();
                chk("R1 oe on select", {8'b0, spi_miso_oe}, 9'd1);
                xfer(nb ? 9 : 8, mv, -1, 9'h0, mi);
                ss_high();
                chk("R3 miso word", mi, tv);
                chk("R1 oe after release", {8'b0, spi_miso_oe}, 9'd0);
                rd_chk("R4 R7 rx", mv);
            end
        end

        // R9: repeat previous character when nothing is written
        setup(1'b0, 1'b0, 1'b0, 1'b0, 9'h0);
        write(9'h03C);
        ss_low();
        for (int k = 0; k < 3; k++) begin
            xfer(8, 9'(8'h21 + k * 8'h13), -1, 9'h0, mi);
            chk("R9 repeated char", mi, 9'h03C);
            rd_chk("R7 stream rx", 9'(8'h21 + k * 8'h13));
        end
        ss_high();

        // R10: late write held, early write taken
        setup(1'b0, 1'b1, 1'b0, 1'b0, 9'h0);
        write(9'h0A6);
        ss_low();
        xfer(8, 9'h011, 7, 9'h05B, mi);
        chk("R10 first char", mi, 9'h0A6);
        rd_chk("R7 c1", 9'h011);
        xfer(8, 9'h022, -1, 9'h0, mi);
        chk("R10 late write held", mi, 9'h0A6);
        rd_chk("R7 c2", 9'h022);
        xfer(8, 9'h033, 0, 9'h0E1, mi);
        chk("R10 held write sent", mi, 9'h05B);
        rd_chk("R7 c3", 9'h033);
        xfer(8, 9'h044, -1, 9'h0, mi);
        chk("R10 early write taken", mi, 9'h0E1);
        rd_chk("R7 c4", 9'h044);
        ss_high();

        // R8: overflow
        setup(1'b1, 1'b1, 1'b1, 1'b0, 9'h0);
        write(9'h1F0);
        ss_low();
        xfer(9, 9'h123, -1, 9'h0, mi);
        xfer(9, 9'h0AB, -1, 9'h0, mi);
        ss_high();
        chk("R8 overflow set", {8'b0, rx_overflow}, 9'd1);
        rd_chk("R8 older kept", 9'h123);
        cyc(1);
        chk("R8 overflow cleared", {8'b0, rx_overflow}, 9'd0);
        chk("R8 valid cleared", {8'b0, rx_valid}, 9'd0);

        // R5 R6: address match, nine bits
        setup(1'b1, 1'b0, 1'b1, 1'b1, 9'h15A);
        write(9'h0D2);
        ss_low();
        chk("R5 oe low during address", {8'b0, spi_miso_oe}, 9'd0);
        bw = wake_cnt;
        xfer(9, 9'h15A, -1, 9'h0, mi);
        chk("R6 one wake cycle", 9'(wake_cnt - bw), 9'd1);
        chk("R6 oe after match", {8'b0, spi_miso_oe}, 9'd1);
        xfer(9, 9'h0C7, -1, 9'h0, mi);
        chk("R6 data after match", mi, 9'h0D2);
        ss_high();
        rd_chk("R5 data stored", 9'h0C7);
        cyc(1);
        chk("R5 address not stored", {8'b0, rx_valid}, 9'd0);

        // R5: mismatch in lowest bit
        bw = wake_cnt; bo = oe_cnt;
        ss_low();
        xfer(9, 9'h15B, -1, 9'h0, mi);
        xfer(9, 9'h077, -1, 9'h0, mi);
        ss_high();
        chk("R5 mismatch oe cycles", 9'(oe_cnt - bo), 9'd0);
        chk("R5 mismatch nothing stored", {8'b0, rx_valid}, 9'd0);
        chk("R5 mismatch no wake", 9'(wake_cnt - bw), 9'd0);

        // R4 R5: eight-bit address ignores programmed bit 8
        setup(1'b0, 1'b1, 1'b0, 1'b1, 9'h1A5);
        bw = wake_cnt;
        ss_low();
        xfer(8, 9'h0A5, -1, 9'h0, mi);
        chk("R4 eight-bit address match", 9'(wake_cnt - bw), 9'd1);
        xfer(8, 9'h05E, -1, 9'h0, mi);
        ss_high();
        rd_chk("R4 eight-bit data", 9'h05E);

        // R2: partial character then restart
        setup(1'b0, 1'b0, 1'b0, 1'b0, 9'h0);
        write(9'h0B4);
        ss_low();
        xfer(3, 9'h005, -1, 9'h0, mi);
        ss_high();
        chk("R2 partial not stored", {8'b0, rx_valid}, 9'd0);
        ss_low();
        xfer(8, 9'h096, -1, 9'h0, mi);
        ss_high();
        chk("R2 transmit restarts", mi, 9'h0B4);
        rd_chk("R2 receive restarts", 9'h096);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule